// File: doc/BRIEF.md
# One-Turn Delay Comb Feedback Filter

This block is the sampled-data core of a cavity-drive feedback path. It applies a recursive comb filter to a stream of signed gap-return samples. Each output is the current input plus a scaled copy of the output from about one machine turn earlier. The result is large loop gain at every harmonic of the revolution frequency. The sample clock sweeps with the beam and is locked to an integer multiple of the revolution frequency, so one turn is always `TURN_LEN` samples (200 by default). The delay line can therefore be a plain circular buffer whatever the RF frequency. The block needs no RF-locked clock and no I/Q demodulation.

The filter does not delay by a full turn. It shortens the delay by a compensation amount that makes up for the rest of the loop. The compensation comes from a table with one entry per RF harmonic number, indexed by the harmonic number that control supplies. The selected entry is latched only on a revolution tick. A harmonic change therefore re-times the comb at a turn boundary, and the output stream does not pause. Latency from input sample to output is a single register.

A small state machine governs loop closure.
- `ST_OPEN`: the loop enable is low. The output is held at zero and zeros are written into the buffer.
- `ST_FLUSH`: the enable is high but fewer than one full turn of zeros has been written since the loop last ran. The output stays zero and zeros are still written.
- `ST_RUN`: the filter runs.

The transitions are:
- OPEN→FLUSH: enable rises while the buffer is not yet clean.
- OPEN→RUN: enable rises when the buffer is already clean.
- FLUSH→RUN: the zero count reaches `TURN_LEN`.
- FLUSH→OPEN and RUN→OPEN: enable falls.
- Every state holds itself otherwise.

The state for a sample is decided in the same cycle that the sample is taken.

Top module: `otc_comb_fb`

## Requirements
- R1: In reset and on the first sample after reset, `y_out` is 0, the compensation is 0 and the zero count is 0. A full turn of zeros must therefore be written before the filter runs.
- R2: When `en_in` is low at a clock edge, `y_out` is 0 after that edge, whatever the values of `x_in` and `gain_in`.
- R3: Every sample taken while the loop is open or flushing writes a zero into the buffer. After `en_in` rises, `y_out` stays 0 until `TURN_LEN` such zero samples have been taken since the filter last ran. The sample taken once that count is reached is the first filtered one.
- R4: While running, the input sample taken at an edge gives `y_out` after that same edge as y = sat(x + floor(k·y[n−D] / 2^15)). Here k is `gain_in`, a signed Q1.15 value; y[n−D] is the output D samples earlier; and D = `TURN_LEN` − c, where c is the active compensation.
- R5: With k = 0 the output equals the input. A single impulse with k = 0.5 (0x4000) recurs every D samples, with its amplitude halved (rounded toward minus infinity) at each recurrence.
- R6: The compensation for harmonic h is bits [h·6 +: 6] of `comp_tab_in`. It is loaded when `rev_tick_in` is high at an edge and applies from the next sample on, including the extreme value 63 (D = 137).
- R7: A change of `harm_in` without a revolution tick leaves the active delay unchanged.
- R8: A result above 8191 gives exactly 8191, and a result below −8192 gives exactly −8192. The output never wraps.
- R9: A negative gain (k = −0.5, 0xC000) feeds back the delayed output with inverted sign, under the same rounding rule as R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sweeping sample clock, one sample per edge |
| rst | input | 1 | Synchronous reset, active high |
| en_in | input | 1 | Loop closed when high |
| rev_tick_in | input | 1 | Revolution marker, one clock wide |
| harm_in | input | 5 | Current RF harmonic number, used as the table index |
| comp_tab_in | input | 192 | 32 compensation entries of 6 bits, entry h at bits h·6 upward |
| gain_in | input | 16 | Comb gain k, signed Q1.15 |
| x_in | input | 14 | Gap-return sample, signed |
| y_out | output | 14 | Correction sample for the drive, signed |

## Verification
Random input with zero gain shows that the pass-through path is right and that latency is one cycle. A lone impulse with a gain of one half makes the recursion visible: it shows the delay length and the floor rounding sample by sample. Random data with a gain of one half is then run under three compensation settings: the unchanged harmonic, a harmonic changed without a tick, and ticks to entries 10 and 63. This tells whether the delay follows the tick rather than the harmonic input. Large constant inputs near full gain drive both saturation rails. A negative gain separates sign handling from magnitude. Opening the loop part-way through a run and closing it early shows whether the flush counts zeros or merely waits.

// File: rtl/otc_pkg.sv
package otc_pkg;

    // Loop-closure modes of the comb filter
    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_RUN   = 2'd2
    } loop_state_e;

endpackage

// File: rtl/otc_comp_sel.sv
// Harmonic-indexed delay-compensation selector, latched at turn boundaries
module otc_comp_sel #(
    parameter int HARM_W = 5,
    parameter int COMP_W = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 tick,
    input  logic [HARM_W-1:0]                    harm,
    input  logic [(1<<HARM_W)*COMP_W-1:0]        tab,
    output logic [COMP_W-1:0]                    comp_q
);
    localparam int NUM_HARM = 1 << HARM_W;

    logic [COMP_W-1:0] slot [NUM_HARM];

    for (genvar g = 0; g < NUM_HARM; g++) begin : g_unpack
        assign slot[g] = tab[g*COMP_W +: COMP_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_q <= '0;
        end else if (tick) begin
            comp_q <= slot[harm];
        end
    end
endmodule

// File: rtl/otc_delay_ring.sv
// Circular one-turn buffer with a read pointer offset by the compensation
module otc_delay_ring #(
    parameter int DEPTH  = 200,
    parameter int DATA_W = 14,
    parameter int COMP_W = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic signed [DATA_W-1:0]  wr_data,
    input  logic [COMP_W-1:0]         comp,
    output logic signed [DATA_W-1:0]  rd_data
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int SUM_W = PTR_W + 1;

    logic signed [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]         wp_q;
    logic [SUM_W-1:0]         rd_sum;
    logic [PTR_W-1:0]         rd_ptr;

    // Reading at wp + c is the same as reading DEPTH - c samples back
    always_comb begin
        rd_sum = {1'b0, wp_q} + SUM_W'(comp);
        if (rd_sum >= SUM_W'(DEPTH)) begin
            rd_sum = rd_sum - SUM_W'(DEPTH);
        end
        rd_ptr = rd_sum[PTR_W-1:0];
    end

    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q <= '0;
        end else if (wp_q == PTR_W'(DEPTH - 1)) begin
            wp_q <= '0;
        end else begin
            wp_q <= wp_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        mem[wp_q] <= wr_data;
    end
endmodule

// File: rtl/otc_comb_math.sv
// Gain multiply, Q1.15 rescale and saturating sum
module otc_comb_math #(
    parameter int DATA_W = 14,
    parameter int GAIN_W = 16
) (
    input  logic signed [DATA_W-1:0] x,
    input  logic signed [DATA_W-1:0] yd,
    input  logic signed [GAIN_W-1:0] gain,
    output logic signed [DATA_W-1:0] y_sat
);
    localparam int PROD_W = GAIN_W + DATA_W;
    localparam int FRAC   = GAIN_W - 1;
    localparam int SUM_W  = DATA_W + 2;
    localparam logic signed [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [SUM_W-1:0]  sum_w;

    assign prod   = gain * yd;
    assign scaled = prod >>> FRAC;
    assign sum_w  = SUM_W'(x) + SUM_W'(scaled);

    always_comb begin
        if (sum_w > SUM_W'(MAXV)) begin
            y_sat = MAXV;
        end else if (sum_w < SUM_W'(MINV)) begin
            y_sat = MINV;
        end else begin
            y_sat = sum_w[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/otc_comb_fb.sv
// One-turn delay comb feedback filter, top level
module otc_comb_fb
    import otc_pkg::*;
#(
    parameter int TURN_LEN = 200,
    parameter int DATA_W   = 14,
    parameter int GAIN_W   = 16,
    parameter int HARM_W   = 5,
    parameter int COMP_W   = 6
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  en_in,
    input  logic                                  rev_tick_in,
    input  logic [HARM_W-1:0]                     harm_in,
    input  logic [(1<<HARM_W)*COMP_W-1:0]         comp_tab_in,
    input  logic signed [GAIN_W-1:0]              gain_in,
    input  logic signed [DATA_W-1:0]              x_in,
    output logic signed [DATA_W-1:0]              y_out
);
    localparam int CNT_W = $clog2(TURN_LEN + 1);
    localparam logic [CNT_W-1:0] CLEAN = CNT_W'(TURN_LEN);

    loop_state_e              state_q, state_d;
    logic [CNT_W-1:0]         zero_cnt;
    logic                     run_now;
    logic [COMP_W-1:0]        act_comp;
    logic signed [DATA_W-1:0] delayed;
    logic signed [DATA_W-1:0] filt;
    logic signed [DATA_W-1:0] wr_val;

    // Next state; it also names the mode of the sample taken at this edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: begin
                if (en_in && zero_cnt == CLEAN) state_d = ST_RUN;
                else if (en_in)                 state_d = ST_FLUSH;
                else                            state_d = ST_OPEN;
            end
            ST_FLUSH: begin
                if (!en_in)                     state_d = ST_OPEN;
                else if (zero_cnt == CLEAN)     state_d = ST_RUN;
                else                            state_d = ST_FLUSH;
            end
            ST_RUN: begin
                state_d = en_in ? ST_RUN : ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    assign run_now = (state_d == ST_RUN);

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OPEN;
        else     state_q <= state_d;
    end

    // Outputs and zero-fill counter
    always_ff @(posedge clk) begin
        if (rst) begin
            y_out    <= '0;
            zero_cnt <= '0;
        end else if (run_now) begin
            y_out    <= filt;
            zero_cnt <= '0;
        end else begin
            y_out    <= '0;
            if (zero_cnt != CLEAN) zero_cnt <= zero_cnt + 1'b1;
        end
    end

    assign wr_val = run_now ? filt : '0;

    otc_comp_sel #(
        .HARM_W (HARM_W),
        .COMP_W (COMP_W)
    ) u_sel (
        .clk    (clk),
        .rst    (rst),
        .tick   (rev_tick_in),
        .harm   (harm_in),
        .tab    (comp_tab_in),
        .comp_q (act_comp)
    );

    otc_delay_ring #(
        .DEPTH  (TURN_LEN),
        .DATA_W (DATA_W),
        .COMP_W (COMP_W)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_data (wr_val),
        .comp    (act_comp),
        .rd_data (delayed)
    );

    otc_comb_math #(
        .DATA_W (DATA_W),
        .GAIN_W (GAIN_W)
    ) u_math (
        .x     (x_in),
        .yd    (delayed),
        .gain  (gain_in),
        .y_sat (filt)
    );
endmodule

// File: rtl/otc_comb_fb_chk.sv
module otc_comb_fb_chk
    import otc_pkg::*;
#(
    parameter int TURN_LEN = 200,
    parameter int DATA_W   = 14,
    parameter int COMP_W   = 6,
    parameter int CNT_W    = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en_in,
    input  logic                     rev_tick_in,
    input  logic signed [DATA_W-1:0] y_out,
    input  loop_state_e              state_q,
    input  logic [CNT_W-1:0]         zero_cnt,
    input  logic                     run_now,
    input  logic [COMP_W-1:0]        act_comp,
    input  logic signed [DATA_W+1:0] sum_wide
);
    localparam logic signed [DATA_W+1:0] HI = (DATA_W+2)'((1 << (DATA_W-1)) - 1);
    localparam logic signed [DATA_W+1:0] LO = -(DATA_W+2)'(1 << (DATA_W-1));

    AST_OPEN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en_in |=> (y_out == '0)); // R2

    AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FLUSH) |-> (y_out == '0)); // R3

    AST_RUN_AFTER_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (!run_now && en_in && zero_cnt != CNT_W'(TURN_LEN)) |=> (y_out == '0)); // R3

    AST_COMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rev_tick_in |=> $stable(act_comp)); // R7

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
        (run_now && sum_wide > HI) |=> (y_out == DATA_W'(HI))); // R8

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
        (run_now && sum_wide < LO) |=> (y_out == DATA_W'(LO))); // R8
endmodule

bind otc_comb_fb otc_comb_fb_chk #(
    .TURN_LEN (TURN_LEN),
    .DATA_W   (DATA_W),
    .COMP_W   (COMP_W),
    .CNT_W    (CNT_W)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .en_in       (en_in),
    .rev_tick_in (rev_tick_in),
    .y_out       (y_out),
    .state_q     (state_q),
    .zero_cnt    (zero_cnt),
    .run_now     (run_now),
    .act_comp    (act_comp),
    .sum_wide    (u_math.sum_w)
);

// File: tb/otc_comb_fb_tb_top.sv
module otc_comb_fb_tb_top;
    localparam int L = 200;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en_in = 1'b0;
    logic               rev_tick_in = 1'b0;
    logic [4:0]         harm_in = '0;
    logic [191:0]       comp_tab_in;
    logic signed [15:0] gain_in = '0;
    logic signed [13:0] x_in = '0;
    logic signed [13:0] y_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    // Reference model state
    int m_hist [0:16383];
    int m_n    = 0;
    bit m_run  = 1'b0;
    int m_zc   = 0;
    int m_comp = 0;

    always #2 clk = ~clk;

    otc_comb_fb dut_i (
        .clk         (clk),
        .rst         (rst),
        .en_in       (en_in),
        .rev_tick_in (rev_tick_in),
        .harm_in     (harm_in),
        .comp_tab_in (comp_tab_in),
        .gain_in     (gain_in),
        .x_in        (x_in),
        .y_out       (y_out)
    );

    function automatic int tab_val(int h);
        return (h == 31) ? 63 : 2 * h;
    endfunction

    function automatic int sat14(int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    // Called at a negedge: drives one sample, predicts, pushes at the posedge
    task automatic drive(int x, bit en, int k, bit tick, int h, string tag);
        bit run;
        int y;
        int yd;
        int d;
        x_in        = 14'(x);
        en_in       = en;
        gain_in     = 16'(k);
        rev_tick_in = tick;
        harm_in     = 5'(h);
        run = en && (m_run || m_zc == L);
        if (run) begin
            d  = L - m_comp;
            yd = (m_n >= d) ? m_hist[m_n - d] : 0;
            y  = sat14(x + ((k * yd) >>> 15));
            m_zc = 0;
        end else begin
            y = 0;
            if (m_zc < L) m_zc++;
        end
        m_hist[m_n] = y;
        m_n++;
        m_run = run;
        if (tick) m_comp = tab_val(h);
        @(posedge clk);
        exp_q.push_back(y);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    function automatic int rnd(int lim);
        return int'($urandom_range(0, 2 * lim)) - lim;
    endfunction

    // Monitor: compare one result per clock
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_checks++;
            if (int'(y_out) != e) begin
                n_fail++;
                $display("FAIL %s: y_out=%0d expected=%0d", t, y_out, e);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        for (int h = 0; h < 32; h++) comp_tab_in[h*6 +: 6] = 6'(tab_val(h));
        void'($urandom(7));
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            n_checks++;
            if (y_out != 0) begin
                n_fail++;
                $display("FAIL R1: y_out=%0d expected=0", y_out);
            end
        end
        rst = 1'b0;
        // R2: open loop ignores input
        for (int i = 0; i < 50; i++) drive(rnd(8000), 1'b0, 16'sh7FFF, 1'b0, 0, "R2");
        // R3: flush remainder of the turn
        for (int i = 0; i < 160; i++) drive(rnd(8000), 1'b1, 0, 1'b0, 0, "R3");
        // R5: pass-through with zero gain
        for (int i = 0; i < 250; i++) drive(rnd(8000), 1'b1, 0, 1'b0, 0, "R5");
        // R5: impulse recurrence at half gain
        for (int i = 0; i < L; i++) drive(0, 1'b1, 32'h4000, 1'b0, 0, "R5");
        drive(4001, 1'b1, 32'h4000, 1'b0, 0, "R5");
        for (int i = 0; i < 700; i++) drive(0, 1'b1, 32'h4000, 1'b0, 0, "R5");
        // R4: random data with half gain
        for (int i = 0; i < 300; i++) drive(rnd(3000), 1'b1, 32'h4000, 1'b0, 0, "R4");
        // R7: harmonic changes without a tick
        for (int i = 0; i < 300; i++) drive(rnd(3000), 1'b1, 32'h4000, 1'b0, 5, "R7");
        // R6: tick loads entry 10, then entry 63
        drive(rnd(3000), 1'b1, 32'h4000, 1'b1, 5, "R6");
        for (int i = 0; i < 400; i++) drive(rnd(3000), 1'b1, 32'h4000, 1'b0, 5, "R6");
        drive(rnd(3000), 1'b1, 32'h4000, 1'b1, 31, "R6");
        for (int i = 0; i < 400; i++) drive(rnd(3000), 1'b1, 32'h4000, 1'b0, 31, "R6");
        // R8: positive and negative saturation
        for (int i = 0; i < 300; i++) drive(8000, 1'b1, 32'h7FFF, 1'b0, 31, "R8");
        for (int i = 0; i < 300; i++) drive(-8000, 1'b1, 32'h7FFF, 1'b0, 31, "R8");
        // R9: negative gain
        for (int i = 0; i < 400; i++) drive(rnd(5000), 1'b1, -16384, 1'b0, 31, "R9");
        // R2/R3: open mid-run for part of a turn, then close early
        for (int i = 0; i < 60; i++) drive(rnd(5000), 1'b0, 32'h4000, 1'b0, 0, "R2");
        for (int i = 0; i < 200; i++) drive(rnd(5000), 1'b1, 32'h4000, 1'b0, 0, "R3");
        for (int i = 0; i < 300; i++) drive(rnd(3000), 1'b1, 32'h4000, 1'b0, 0, "R4");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end
endmodule